// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block sits between eight interrupt request lines and the processor's interrupt input. It watches the lines for rising edges and latches each edge into a request register. From these pending requests it picks the one line that should be presented to the processor now.

Priority rotates rather than being fixed. A programmable rotation base names the line that currently has top priority, and the other lines follow it in ascending order, wrapping modulo eight. The surrounding register logic supplies the mask and in-service vectors. The block drops masked requests. The best remaining request is raised only if it strictly outranks the highest line already in service. When special nesting is enabled on a master controller, the cascade line (line 2) is left out of that in-service ranking. This lets a second request arriving through the cascade interrupt its own service.

The acknowledge logic clears request bits through a clear vector. The bus register interface and vector number generation are built outside this block.

Top module: `rpr_resolver`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every pending request and the remembered line levels. After reset with all lines low, `irq_valid` is 0 and `irq_winner` is 0.
- R2: A line that is high at a clock edge, after being sampled low at the previous edge (or cleared by reset), sets its request bit at that edge. With mask and in-service both zero, the request shows on `irq_valid`/`irq_winner` in the cycle that directly follows that edge.
- R3: Each set bit of `ack_clear` clears the matching request bit at the clock edge. If a new rising edge on the same line arrives at that same edge, the request stays set.
- R4: Only requests whose `mask_reg` bit is 0 take part in the contest. A masked request never wins, and it never blocks an unmasked one.
- R5: Relative priority k (0 highest) belongs to line (k + `rot_base`) mod 8. `irq_winner` gives the absolute line number of the winning request.
- R6: `irq_valid` is 1 only when the relative priority of the best unmasked request is strictly higher than the relative priority of the highest set bit of `svc_reg`, both ranked from the same base. A request of equal or lower rank is held off.
- R7: When `nest_special` and `is_master` are both 1, bit 2 of `svc_reg` is ignored in the in-service ranking. In every other combination, bit 2 counts like any other bit.
- R8: When there is no unmasked request, or no request beats the in-service level, `irq_valid` is 0 and `irq_winner` is 0.
- R9: A line held high sets its request bit only once. After that bit is cleared, it sets again only after the line is seen low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 8 | Raw interrupt request lines, edge sensitive |
| ack_clear | input | 8 | Per-line clear of the request register |
| rot_base | input | 3 | Line that currently holds top priority |
| mask_reg | input | 8 | Mask register; 1 blocks the line |
| svc_reg | input | 8 | In-service register |
| nest_special | input | 1 | Special nesting mode enable |
| is_master | input | 1 | 1 when this controller is the master of a cascade |
| irq_valid | output | 1 | An interrupt should be presented to the processor |
| irq_winner | output | 3 | Absolute line number of the chosen request |

## Verification
Directed sequences on a single line separate true edge capture from level sensing. These cover a held-high line, a clear with no new edge, a clear that coincides with a new edge, and reset while a request is pending. A sweep runs over all 256 request patterns against every rotation base. Each point is combined with several mask and in-service vectors, so that rotation errors, mask leakage and a wrong equal-rank comparison each produce a different winner or valid value than the bench's arithmetic ranking. Every point of the sweep is run with the master flag both on and off while special nesting is enabled. In-service vectors holding bit 2 then show whether the cascade exemption applies only to the master.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    // Number of request lines handled by one resolver.
    localparam int unsigned LINE_COUNT      = 8;
    // Line that carries a cascaded controller's request.
    localparam int unsigned CASCADE_DEFAULT = 2;
endpackage

// File: rtl/rpr_capture.sv
// Edge capture and request register for the request lines.
module rpr_capture #(
    parameter int unsigned N_LINES = rpr_pkg::LINE_COUNT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] lines,
    input  logic [N_LINES-1:0] ack_clear,
    output logic [N_LINES-1:0] req_q
);
    typedef struct packed {
        logic [N_LINES-1:0] req;
        logic [N_LINES-1:0] hist;
    } cap_state_t;

    cap_state_t         st_d, st_q;
    logic [N_LINES-1:0] rise;

    always_comb begin
        rise      = lines & ~st_q.hist;
        st_d      = st_q;
        // a fresh edge outranks a clear arriving in the same cycle
        st_d.req  = (st_q.req & ~ack_clear) | rise;
        st_d.hist = lines;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign req_q = st_q.req;

    // R2: an edge seen at this clock leaves its request bit set after it
    a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st_q.req & $past(lines & ~st_q.hist)) == $past(lines & ~st_q.hist)));

    // R3: a cleared bit without a coinciding edge reads zero afterwards
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st_q.req & $past(ack_clear & ~(lines & ~st_q.hist))) == '0));

    // R9: no request bit appears without a low-to-high transition
    a_r9_no_level_set: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st_q.req & ~$past(st_q.req) & ~$past(lines & ~st_q.hist)) == '0));
endmodule

// File: rtl/rpr_scan.sv
// Rotated priority search: returns the relative rank of the first set bit
// counted from the base, or N_LINES when the vector is empty.
module rpr_scan #(
    parameter int unsigned N_LINES = rpr_pkg::LINE_COUNT,
    localparam int unsigned IDXW   = $clog2(N_LINES),
    localparam int unsigned RELW   = $clog2(N_LINES + 1)
) (
    input  logic [N_LINES-1:0] vec,
    input  logic [IDXW-1:0]    base,
    output logic [RELW-1:0]    rel
);
    logic [N_LINES-1:0] rot;

    for (genvar k = 0; k < N_LINES; k++) begin : g_rot
        always_comb begin
            int unsigned src;
            src = k + int'(base);
            if (src >= N_LINES) begin
                src = src - N_LINES;
            end
            rot[k] = vec[src];
        end
    end

    always_comb begin
        rel = RELW'(N_LINES);
        for (int k = N_LINES - 1; k >= 0; k--) begin
            if (rot[k]) begin
                rel = RELW'(k);
            end
        end
    end
endmodule

// File: rtl/rpr_resolver.sv
// Top: masks requests, ranks them and the in-service set, picks a winner.
module rpr_resolver #(
    parameter int unsigned N_LINES      = rpr_pkg::LINE_COUNT,
    parameter int unsigned CASCADE_LINE = rpr_pkg::CASCADE_DEFAULT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_LINES-1:0]         irq_lines,
    input  logic [N_LINES-1:0]         ack_clear,
    input  logic [$clog2(N_LINES)-1:0] rot_base,
    input  logic [N_LINES-1:0]         mask_reg,
    input  logic [N_LINES-1:0]         svc_reg,
    input  logic                       nest_special,
    input  logic                       is_master,
    output logic                       irq_valid,
    output logic [$clog2(N_LINES)-1:0] irq_winner
);
    localparam int unsigned IDXW = $clog2(N_LINES);
    localparam int unsigned RELW = $clog2(N_LINES + 1);

    logic [N_LINES-1:0] req_q;
    logic [N_LINES-1:0] cand;
    logic [N_LINES-1:0] svc_eff;
    logic [RELW-1:0]    pend_rel;
    logic [RELW-1:0]    cur_rel;

    rpr_capture #(.N_LINES(N_LINES)) i_capture (
        .clk       (clk),
        .rst       (rst),
        .lines     (irq_lines),
        .ack_clear (ack_clear),
        .req_q     (req_q)
    );

    always_comb begin
        cand    = req_q & ~mask_reg;
        svc_eff = svc_reg;
        if (nest_special && is_master) begin
            svc_eff[CASCADE_LINE] = 1'b0;
        end
    end

    rpr_scan #(.N_LINES(N_LINES)) i_scan_pend (
        .vec  (cand),
        .base (rot_base),
        .rel  (pend_rel)
    );

    rpr_scan #(.N_LINES(N_LINES)) i_scan_svc (
        .vec  (svc_eff),
        .base (rot_base),
        .rel  (cur_rel)
    );

    always_comb begin
        int unsigned abs_line;
        abs_line  = int'(pend_rel) + int'(rot_base);
        if (abs_line >= N_LINES) begin
            abs_line = abs_line - N_LINES;
        end
        // the in-service rank is at most N_LINES, so an empty candidate never wins
        irq_valid  = (pend_rel < cur_rel);
        irq_winner = irq_valid ? IDXW'(abs_line) : '0;
    end

    // R4: the winner is a pending, unmasked line
    a_r4_winner_unmasked: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (!mask_reg[irq_winner] && req_q[irq_winner]));

    // R6, R7: a winner is never already in service, bar the exempt cascade line
    a_r6_not_in_service: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !(nest_special && is_master && irq_winner == IDXW'(CASCADE_LINE)))
        |-> !svc_reg[irq_winner]);

    // R5: a pending unmasked request at the base line wins when nothing is in service
    a_r5_base_line_first: assert property (@(posedge clk) disable iff (rst)
        (req_q[rot_base] && !mask_reg[rot_base] && svc_reg == '0)
        |-> (irq_valid && irq_winner == rot_base));

    // R8: no unmasked request means no interrupt and a zero index
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        ((req_q & ~mask_reg) == '0) |-> (!irq_valid && irq_winner == '0));
endmodule

// File: tb/test_rpr_resolver.sv
`timescale 1ns/100ps
module test_rpr_resolver;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_lines, ack_clear, mask_reg, svc_reg;
    logic [2:0] rot_base;
    logic       nest_special, is_master;
    logic       irq_valid;
    logic [2:0] irq_winner;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    rpr_resolver i_rpr_resolver (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .ack_clear(ack_clear),
        .rot_base(rot_base), .mask_reg(mask_reg), .svc_reg(svc_reg),
        .nest_special(nest_special), .is_master(is_master),
        .irq_valid(irq_valid), .irq_winner(irq_winner)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // rank of the first set bit counted from base, 8 when empty
    function automatic int rank(input logic [7:0] v, input int b);
        for (int k = 0; k < 8; k++) begin
            if (v[(k + b) % 8]) return k;
        end
        return 8;
    endfunction

    task automatic check_outputs(input string req, input logic [7:0] pend);
        logic [7:0] s;
        int pr, cr, ev, ew;
        s = svc_reg;
        if (nest_special && is_master) s[2] = 1'b0;
        pr = rank(pend & ~mask_reg, rot_base);
        cr = rank(s, rot_base);
        ev = (pr < cr) ? 1 : 0;
        ew = ev ? (pr + rot_base) % 8 : 0;
        check({req, " valid"}, irq_valid, ev);
        check({req, " winner"}, irq_winner, ew);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; irq_lines = 8'h00; ack_clear = 8'h00; mask_reg = 8'h00;
        svc_reg = 8'h00; rot_base = 3'd0; nest_special = 1'b0; is_master = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset valid", irq_valid, 0);
        check("R1 reset winner", irq_winner, 0);

        // R2: rising edge on line 5 seen right after the capturing edge
        irq_lines = 8'h20;
        @(negedge clk);
        check("R2 edge valid", irq_valid, 1);
        check("R2 edge winner", irq_winner, 5);

        // R3: clear while held high, no new edge
        ack_clear = 8'h20;
        @(negedge clk);
        ack_clear = 8'h00;
        check("R3 clear valid", irq_valid, 0);
        @(negedge clk);
        check("R9 held high no reset", irq_valid, 0);

        // R9: low then high re-arms
        irq_lines = 8'h00;
        @(negedge clk);
        check("R9 low stays idle", irq_valid, 0);
        irq_lines = 8'h20;
        @(negedge clk);
        check("R9 re-edge valid", irq_valid, 1);
        check("R9 re-edge winner", irq_winner, 5);

        // R3: clear coinciding with a fresh edge keeps the request
        ack_clear = 8'h20; irq_lines = 8'h00;
        @(negedge clk);
        ack_clear = 8'h20; irq_lines = 8'h20;
        @(negedge clk);
        ack_clear = 8'h00;
        check("R3 edge beats clear", irq_valid, 1);
        check("R3 edge beats clear winner", irq_winner, 5);

        // R1: reset drops a pending request
        irq_lines = 8'h00;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears pending", irq_valid, 0);
        @(negedge clk);
        check("R1 idle after reset", irq_valid, 0);

        // R4..R8: sweep every request pattern against bases, masks, service, modes
        for (int p = 0; p < 256; p++) begin
            irq_lines = 8'h00; ack_clear = 8'hFF;
            @(negedge clk);
            ack_clear = 8'h00; irq_lines = 8'(p);
            @(negedge clk);
            for (int b = 0; b < 8; b++) begin
                for (int mi = 0; mi < 2; mi++) begin
                    for (int si = 0; si < 4; si++) begin
                        for (int md = 0; md < 2; md++) begin
                            rot_base     = 3'(b);
                            mask_reg     = (mi == 0) ? 8'h00 : 8'((p * 3) & 8'hA5);
                            case (si)
                                0: svc_reg = 8'h00;
                                1: svc_reg = 8'h04;
                                2: svc_reg = 8'h01 << p[5:3];
                                default: svc_reg = 8'(p) ^ 8'h5A;
                            endcase
                            nest_special = 1'b1;
                            is_master    = md[0];
                            #1;
                            if (si == 0)       check_outputs("R5 rotation", 8'(p));
                            else if (si == 1)  check_outputs("R7 cascade exemption", 8'(p));
                            else if (mi == 1)  check_outputs("R4 mask", 8'(p));
                            else               check_outputs("R6 strict nesting", 8'(p));
                            if (p == 0)        check("R8 idle", irq_valid, 0);
                            @(negedge clk);
                        end
                    end
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule